// File: doc/BRIEF.md
# Byte/Word Arithmetic Unit with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style processor whose data path is mostly one byte wide, with a few word-wide operations. It is purely combinational. The block receives an operation code, a first operand, a second operand and the current status byte. In the same cycle it returns a result word and the new status byte. The surrounding pipeline fetches the operands, writes registers and sequences branches.

The status byte holds five flags that the block computes: carry (bit 0), overflow (bit 1), zero (bit 2), negative (bit 3) and half-carry (bit 5). Bits 4, 6 and 7 are interrupt-mask and state bits that the block never alters. Each operation has a fixed set of flags it writes. Every other flag is copied unchanged from the input status byte. Byte operations use only the low byte of each operand and return a result with the upper byte zero.

Top module: `alu_ccr_core`

## Requirements
- R1: Operation codes (op_i): 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 and, 6 or, 7 xor, 8 bit-test, 9 load, 10 store, 11 negate, 12 complement, 13 clear, 14 increment, 15 decrement, 16 logical right shift, 17 arithmetic right shift, 18 rotate right, 19 rotate left, 20 arithmetic left shift, 21 decimal adjust, 22 word add, 23 word subtract, 24 word compare. Codes 0 to 21 use only bits 7:0 of the operands and return res_o[15:8] = 0. Codes 25 to 31 return a_i unchanged with cc_o equal to cc_i.
- R2: Byte add, add-with-carry, subtract and subtract-with-borrow form a 9-bit result r = a+b(+C) or a-b(-C). res_o = r[7:0], C = r[8], H = bit 4 of a^b^r, V = bit 7 of a^b^r^(r>>1), and N and Z come from r[7:0]. The other status bits are unchanged.
- R3: Compare sets the flags exactly as subtract does, and returns the first operand unchanged: the low byte for byte compare, the whole word for word compare. Bit-test also returns the first operand unchanged.
- R4: And, or, xor, bit-test, load (result = b_i[7:0]) and store (result = a_i[7:0]) set N and Z from their value and clear V. C and H are unchanged.
- R5: Increment and decrement set N and Z. V is set only when the incremented result is 0x80, or when the decremented result is 0x7F. C and H are unchanged.
- R6: Complement returns ~a, sets N and Z, sets C and clears V. Clear returns 0, with N=0, V=0, Z=1 and C=0. H is unchanged for both.
- R7: The logical right shift, arithmetic right shift and rotate right move a[0] into C. The logical shift fills bit 7 with 0, the arithmetic shift keeps a[7], and the rotate fills bit 7 with the incoming C. N and Z follow the result. V and H are unchanged.
- R8: Rotate left moves a[7] into C and the incoming C into bit 0. It sets N and Z and leaves V and H unchanged. The arithmetic left shift behaves as an add of the operand to itself without carry-in, using the flag rules of R2.
- R9: Decimal adjust starts from a. It adds 6 if H is set, then adds 6 if the low nibble now exceeds 9, then adds 0x60 if C is set, then adds 0x60 if bits 7:4 now exceed 9. The result is the low byte, and C becomes bit 8 of the sum. No other flag changes.
- R10: For word add, subtract and compare the result r is 17 bits. C = r[16], V = bit 15 of a^b^r^(r>>1), and N and Z come from r[15:0]. H is unchanged.
- R11: Status bits 4, 6 and 7 always equal the matching bits of cc_i.
- R12: Negate computes 0 - a with the subtract flag rules of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (encoding in R1) |
| a_i | input | 16 | First operand (low byte for byte operations) |
| b_i | input | 16 | Second operand (low byte for byte operations) |
| cc_i | input | 8 | Current status byte |
| res_o | output | 16 | Operation result |
| cc_o | output | 8 | Updated status byte |

## Verification
Every result and every status bit is due in the same cycle as the inputs, with no register between them. The bench changes the inputs just after a falling clock edge. It reads res_o and cc_o a quarter period later, well before the next rising edge, so no check can see a half-updated value. The expected values are worked out by hand from the requirement formulas. They cover carries, borrows, the signed-overflow boundaries 0x7F/0x80, the decimal-adjust carry chain and the word-wide carry out.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int CC_W   = 8;
  localparam int NIB_W  = 4;
  localparam int PAD_W  = WORD_W - BYTE_W;

  // status bit positions (decoded by neighbouring branch logic)
  localparam int CC_C = 0;
  localparam int CC_V = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;
  localparam int CC_H = 5;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_BIT  = 5'd8,  OP_LD   = 5'd9,  OP_ST   = 5'd10, OP_NEG  = 5'd11,
    OP_COM  = 5'd12, OP_CLR  = 5'd13, OP_INC  = 5'd14, OP_DEC  = 5'd15,
    OP_LSR  = 5'd16, OP_ASR  = 5'd17, OP_ROR  = 5'd18, OP_ROL  = 5'd19,
    OP_ASL  = 5'd20, OP_DAA  = 5'd21, OP_ADDW = 5'd22, OP_SUBW = 5'd23,
    OP_CMPW = 5'd24
  } alu_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] res;
    logic [CC_W-1:0]   flg;
    logic [CC_W-1:0]   wr;
  } alu_out_t;

  function automatic logic [CC_W-1:0] mk_cc(input logic h, input logic n,
                                            input logic z, input logic v,
                                            input logic c);
    logic [CC_W-1:0] f;
    f       = '0;
    f[CC_H] = h;
    f[CC_N] = n;
    f[CC_Z] = z;
    f[CC_V] = v;
    f[CC_C] = c;
    return f;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int EW = W + 1;

  logic [EW-1:0] xe, ye, ce, r;

  always_comb begin
    xe = {1'b0, x_i};
    ye = {1'b0, y_i};
    ce = {{W{1'b0}}, cin_i};
    r  = sub_i ? (xe - ye - ce) : (xe + ye + ce);
  end

  assign sum_o  = r[W-1:0];
  assign cout_o = r[W];
  // sign of operands, result and the bit shifted down from the carry
  assign ovf_o  = x_i[W-1] ^ y_i[W-1] ^ r[W-1] ^ r[W];

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_cc_pkg::*;
(
  input  alu_op_e          op_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic             c_i,
  output alu_out_t         out_o
);
  localparam logic [BYTE_W-1:0] INC_OVF = 8'h80;
  localparam logic [BYTE_W-1:0] DEC_OVF = 8'h7F;
  localparam logic [BYTE_W-1:0] ONE     = 8'h01;

  logic [BYTE_W-1:0] r, f;
  logic              c, v, wr_c, wr_v;

  always_comb begin
    r    = a_i;
    c    = c_i;
    v    = 1'b0;
    wr_c = 1'b0;
    wr_v = 1'b1;
    case (op_i)
      OP_AND: r = a_i & b_i;
      OP_OR:  r = a_i | b_i;
      OP_XOR: r = a_i ^ b_i;
      OP_BIT: r = a_i & b_i;
      OP_LD:  r = b_i;
      OP_ST:  r = a_i;
      OP_COM: begin r = ~a_i; c = 1'b1; wr_c = 1'b1; end
      OP_CLR: begin r = '0;   c = 1'b0; wr_c = 1'b1; end
      OP_INC: begin r = a_i + ONE; v = (r == INC_OVF); end
      OP_DEC: begin r = a_i - ONE; v = (r == DEC_OVF); end
      OP_LSR: begin r = {1'b0, a_i[BYTE_W-1:1]};          c = a_i[0]; wr_c = 1'b1; wr_v = 1'b0; end
      OP_ASR: begin r = {a_i[BYTE_W-1], a_i[BYTE_W-1:1]}; c = a_i[0]; wr_c = 1'b1; wr_v = 1'b0; end
      OP_ROR: begin r = {c_i, a_i[BYTE_W-1:1]};           c = a_i[0]; wr_c = 1'b1; wr_v = 1'b0; end
      OP_ROL: begin r = {a_i[BYTE_W-2:0], c_i}; c = a_i[BYTE_W-1]; wr_c = 1'b1; wr_v = 1'b0; end
      default: wr_v = 1'b0;
    endcase
    // bit-test sets flags from the masked value but hands the operand back
    f = r;
    if (op_i == OP_BIT) r = a_i;
    out_o.res = {{PAD_W{1'b0}}, r};
    out_o.flg = mk_cc(1'b0, f[BYTE_W-1], (f == '0), v, c);
    out_o.wr  = mk_cc(1'b0, 1'b1, 1'b1, wr_v, wr_c);
  end

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
  import alu_cc_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic              h_i,
  input  logic              c_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              c_o
);
  localparam int TW = BYTE_W + 2;
  localparam logic [TW-1:0]    ADJ_LO = TW'(6);
  localparam logic [TW-1:0]    ADJ_HI = TW'(6) << NIB_W;
  localparam logic [NIB_W-1:0] DIG_MAX = NIB_W'(9);

  logic [TW-1:0] t0, t1, t2, t3;

  always_comb begin
    t0 = {2'b00, a_i} + (h_i ? ADJ_LO : '0);
    t1 = t0 + ((t0[NIB_W-1:0] > DIG_MAX) ? ADJ_LO : '0);
    t2 = t1 + (c_i ? ADJ_HI : '0);
    t3 = t2 + ((t2[BYTE_W-1:NIB_W] > DIG_MAX) ? ADJ_HI : '0);
  end

  assign res_o = t3[BYTE_W-1:0];
  assign c_o   = t3[BYTE_W];

endmodule

// File: rtl/alu_ccr_core.sv
module alu_ccr_core
  import alu_cc_pkg::*;
(
  input  logic [4:0]        op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic [WORD_W-1:0] res_o,
  output logic [CC_W-1:0]   cc_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [BYTE_W-1:0] ax, bx;
  assign ax = a_i[BYTE_W-1:0];
  assign bx = b_i[BYTE_W-1:0];

  // byte adder operand steering
  logic [BYTE_W-1:0] x8, y8, sum8, hx8;
  logic              cin8, sub8, cout8, ovf8, h8;

  always_comb begin
    x8   = ax;
    y8   = bx;
    cin8 = 1'b0;
    sub8 = 1'b0;
    case (op)
      OP_ADC:         cin8 = cc_i[CC_C];
      OP_SUB, OP_CMP: sub8 = 1'b1;
      OP_SBC: begin sub8 = 1'b1; cin8 = cc_i[CC_C]; end
      OP_NEG: begin x8 = '0; y8 = ax; sub8 = 1'b1; end
      OP_ASL:         y8 = ax;
      default: ;
    endcase
  end

  alu_addsub #(.W(BYTE_W)) u_add8 (
    .x_i(x8), .y_i(y8), .cin_i(cin8), .sub_i(sub8),
    .sum_o(sum8), .cout_o(cout8), .ovf_o(ovf8)
  );

  assign hx8 = x8 ^ y8 ^ sum8;
  assign h8  = hx8[NIB_W];

  logic [WORD_W-1:0] sum16;
  logic              cout16, ovf16;

  alu_addsub #(.W(WORD_W)) u_add16 (
    .x_i(a_i), .y_i(b_i), .cin_i(1'b0), .sub_i(op != OP_ADDW),
    .sum_o(sum16), .cout_o(cout16), .ovf_o(ovf16)
  );

  alu_out_t bit_out;

  alu_bitops u_bits (
    .op_i(op), .a_i(ax), .b_i(bx), .c_i(cc_i[CC_C]), .out_o(bit_out)
  );

  logic [BYTE_W-1:0] daa_res;
  logic              daa_c;

  alu_decadj u_daa (
    .a_i(ax), .h_i(cc_i[CC_H]), .c_i(cc_i[CC_C]),
    .res_o(daa_res), .c_o(daa_c)
  );

  alu_out_t sel;

  always_comb begin
    sel.res = a_i;
    sel.flg = '0;
    sel.wr  = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_ASL, OP_CMP: begin
        sel.res = (op == OP_CMP) ? {{PAD_W{1'b0}}, ax} : {{PAD_W{1'b0}}, sum8};
        sel.flg = mk_cc(h8, sum8[BYTE_W-1], (sum8 == '0), ovf8, cout8);
        sel.wr  = mk_cc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      end
      OP_AND, OP_OR, OP_XOR, OP_BIT, OP_LD, OP_ST, OP_COM, OP_CLR,
      OP_INC, OP_DEC, OP_LSR, OP_ASR, OP_ROR, OP_ROL:
        sel = bit_out;
      OP_DAA: begin
        sel.res = {{PAD_W{1'b0}}, daa_res};
        sel.flg = mk_cc(1'b0, 1'b0, 1'b0, 1'b0, daa_c);
        sel.wr  = mk_cc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      end
      OP_ADDW, OP_SUBW, OP_CMPW: begin
        sel.res = (op == OP_CMPW) ? a_i : sum16;
        sel.flg = mk_cc(1'b0, sum16[WORD_W-1], (sum16 == '0), ovf16, cout16);
        sel.wr  = mk_cc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      end
      default: ;
    endcase
  end

  assign res_o = sel.res;
  assign cc_o  = (cc_i & ~sel.wr) | (sel.flg & sel.wr);

endmodule

// File: rtl/alu_ccr_core_chk.sv
module alu_ccr_core_chk (
  input logic [4:0]  op_i,
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic [7:0]  cc_i,
  input logic [15:0] res_o,
  input logic [7:0]  cc_o
);
  always_comb begin
    if (!$isunknown({op_i, a_i, b_i, cc_i})) begin
      // R11
      keep_sys_bits_chk: assert ({cc_o[7:6], cc_o[4]} == {cc_i[7:6], cc_i[4]})
        else $error("system status bits altered");
      // R1
      byte_upper_zero_chk: assert (op_i > 5'd21 || res_o[15:8] == 8'h00)
        else $error("byte op upper result byte not zero");
      // R1
      undef_pass_chk: assert (op_i < 5'd25 || (res_o == a_i && cc_o == cc_i))
        else $error("undefined op changed state");
      // R3
      cmp_keeps_a_chk: assert (!(op_i == 5'd4 || op_i == 5'd8) || res_o == {8'h00, a_i[7:0]})
        else $error("byte compare/test altered operand");
      // R4
      logic_flags_chk: assert (!(op_i >= 5'd5 && op_i <= 5'd10) ||
                               (cc_o[1] == 1'b0 && cc_o[0] == cc_i[0] && cc_o[5] == cc_i[5]))
        else $error("logic op flag rule broken");
      // R4
      load_value_chk: assert (op_i != 5'd9 || res_o[7:0] == b_i[7:0])
        else $error("load value wrong");
      // R5
      inc_ovf_chk: assert (op_i != 5'd14 || (cc_o[1] == (res_o[7:0] == 8'h80) && cc_o[0] == cc_i[0]))
        else $error("increment overflow rule broken");
      // R6
      clr_flags_chk: assert (op_i != 5'd13 || (res_o == 16'h0000 && cc_o[3:0] == 4'b0100))
        else $error("clear rule broken");
      // R7
      lsr_carry_chk: assert (op_i != 5'd16 || (cc_o[0] == a_i[0] && res_o[7] == 1'b0 && cc_o[1] == cc_i[1]))
        else $error("logical right shift rule broken");
      // R10
      word_nz_chk: assert (!(op_i == 5'd22 || op_i == 5'd23) ||
                           (cc_o[2] == (res_o == 16'h0000) && cc_o[3] == res_o[15] && cc_o[5] == cc_i[5]))
        else $error("word N/Z rule broken");
    end
  end
endmodule

bind alu_ccr_core alu_ccr_core_chk u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .cc_i(cc_i), .res_o(res_o), .cc_o(cc_o)
);

// File: tb/sim_alu_ccr_core.sv
module sim_alu_ccr_core;
  import alu_cc_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [4:0]  op;
  logic [15:0] a, b, res;
  logic [7:0]  cc, cco;
  int          n_chk, n_fail, cyc;
  logic        done;

  alu_ccr_core u0 (.op_i(op), .a_i(a), .b_i(b), .cc_i(cc), .res_o(res), .cc_o(cco));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // task names the requirement; inputs change after the falling edge,
  // combinational outputs are read 5 ns later, before the rising edge
  task automatic run(input string req, input alu_op_e o, input logic [15:0] av,
                     input logic [15:0] bv, input logic [7:0] cv,
                     input logic [15:0] er, input logic [7:0] ec);
    @(negedge clk);
    op = o; a = av; b = bv; cc = cv;
    #5;
    n_chk++;
    if (res !== er || cco !== ec) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h cc=%h: res=%h cc=%h expected res=%h cc=%h",
               req, o, av, bv, cv, res, cco, er, ec);
    end
  endtask

  task automatic t_reset_state();
    run("R2", OP_ADD, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h04);
  endtask

  task automatic t_add8();
    run("R2", OP_ADD, 16'h007F, 16'h0001, 8'h00, 16'h0080, 8'h2A);
    run("R2", OP_ADD, 16'h00FF, 16'h0001, 8'h00, 16'h0000, 8'h25);
    run("R2", OP_ADC, 16'h0010, 16'h0020, 8'h81, 16'h0031, 8'h80);
    run("R1", OP_ADD, 16'hFF7F, 16'hAA01, 8'h00, 16'h0080, 8'h2A);
  endtask

  task automatic t_sub8();
    run("R2", OP_SUB, 16'h0000, 16'h0001, 8'h00, 16'h00FF, 8'h29);
    run("R2", OP_SUB, 16'h0080, 16'h0001, 8'h00, 16'h007F, 8'h22);
    run("R2", OP_SBC, 16'h0005, 16'h0003, 8'h01, 16'h0001, 8'h00);
  endtask

  task automatic t_compare();
    run("R3", OP_CMP, 16'h0042, 16'h0042, 8'h00, 16'h0042, 8'h04);
    run("R3", OP_BIT, 16'h0055, 16'h00AA, 8'h0A, 16'h0055, 8'h04);
    run("R3", OP_CMPW, 16'h1000, 16'h2000, 8'h00, 16'h1000, 8'h09);
  endtask

  task automatic t_logic();
    run("R4", OP_AND, 16'h00F0, 16'h008F, 8'h03, 16'h0080, 8'h09);
    run("R4", OP_OR,  16'h0000, 16'h0000, 8'h2A, 16'h0000, 8'h24);
    run("R4", OP_XOR, 16'h00FF, 16'h000F, 8'h00, 16'h00F0, 8'h08);
    run("R4", OP_LD,  16'h0033, 16'h0000, 8'h0B, 16'h0000, 8'h05);
    run("R4", OP_ST,  16'h009C, 16'h0011, 8'h00, 16'h009C, 8'h08);
  endtask

  task automatic t_incdec();
    run("R5", OP_INC, 16'h007F, 16'h0000, 8'h01, 16'h0080, 8'h0B);
    run("R5", OP_INC, 16'h00FF, 16'h0000, 8'h00, 16'h0000, 8'h04);
    run("R5", OP_DEC, 16'h0080, 16'h0000, 8'h00, 16'h007F, 8'h02);
    run("R5", OP_DEC, 16'h0001, 16'h0000, 8'h01, 16'h0000, 8'h05);
  endtask

  task automatic t_comclr();
    run("R6", OP_COM, 16'h00FF, 16'h0000, 8'h02, 16'h0000, 8'h05);
    run("R6", OP_CLR, 16'h00A5, 16'h0000, 8'hFF, 16'h0000, 8'hF4);
  endtask

  task automatic t_shift_right();
    run("R7", OP_LSR, 16'h0081, 16'h0000, 8'h02, 16'h0040, 8'h03);
    run("R7", OP_ASR, 16'h0081, 16'h0000, 8'h00, 16'h00C0, 8'h09);
    run("R7", OP_ROR, 16'h0001, 16'h0000, 8'h01, 16'h0080, 8'h09);
    run("R7", OP_ROR, 16'h0002, 16'h0000, 8'h00, 16'h0001, 8'h00);
  endtask

  task automatic t_shift_left();
    run("R8", OP_ROL, 16'h0080, 16'h0000, 8'h00, 16'h0000, 8'h05);
    run("R8", OP_ROL, 16'h0040, 16'h0000, 8'h01, 16'h0081, 8'h08);
    run("R8", OP_ASL, 16'h00C0, 16'h0000, 8'h00, 16'h0080, 8'h09);
    run("R8", OP_ASL, 16'h0040, 16'h0000, 8'h00, 16'h0080, 8'h0A);
  endtask

  task automatic t_daa();
    run("R9", OP_DAA, 16'h003C, 16'h0000, 8'h00, 16'h0042, 8'h00);
    run("R9", OP_DAA, 16'h0000, 16'h0000, 8'h21, 16'h0066, 8'h20);
    run("R9", OP_DAA, 16'h009A, 16'h0000, 8'h00, 16'h0000, 8'h01);
  endtask

  task automatic t_word();
    run("R10", OP_ADDW, 16'h7FFF, 16'h0001, 8'h00, 16'h8000, 8'h0A);
    run("R10", OP_ADDW, 16'hFFFF, 16'h0001, 8'h20, 16'h0000, 8'h25);
    run("R10", OP_SUBW, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h09);
    run("R10", OP_SUBW, 16'h8000, 16'h0001, 8'h00, 16'h7FFF, 8'h02);
    run("R10", OP_CMPW, 16'h1234, 16'h1234, 8'h00, 16'h1234, 8'h04);
  endtask

  task automatic t_passthru();
    run("R11", OP_AND, 16'h0001, 16'h0001, 8'hD0, 16'h0001, 8'hD0);
    run("R1", alu_op_e'(5'd31), 16'hABCD, 16'h1234, 8'h5A, 16'hABCD, 8'h5A);
    run("R1", alu_op_e'(5'd25), 16'h00FF, 16'h0000, 8'hFF, 16'h00FF, 8'hFF);
  endtask

  task automatic t_neg();
    run("R12", OP_NEG, 16'h0001, 16'h0000, 8'h00, 16'h00FF, 8'h29);
    run("R12", OP_NEG, 16'h0080, 16'h0000, 8'h00, 16'h0080, 8'h0B);
    run("R12", OP_NEG, 16'h0000, 16'h0000, 8'h01, 16'h0000, 8'h04);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected under 5000", cyc);
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0;
    op = 5'd0; a = '0; b = '0; cc = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add8();
    t_sub8();
    t_compare();
    t_logic();
    t_incdec();
    t_comclr();
    t_shift_right();
    t_shift_left();
    t_daa();
    t_word();
    t_passthru();
    t_neg();
    @(negedge clk);
    finish_run();
  end

endmodule